// File: doc/BRIEF.md
# Clock Slow-Down and Stop Indicator with Automatic Switchback

This block produces the two indicators that an external clock controller uses to slow the core clock down or to halt it. Software writes a small control word that turns on the slow-clock mode, requests a clock stop, enables automatic switchback and selects which wake sources may end a stop. The clock divider and the clock gate are outside the block; it only drives their level requests.

When switchback is enabled, a pending or active interrupt, or a busy serial port, pulls the core back to full speed for as long as the activity lasts, plus a fixed hold-off window. After that the slow mode returns by itself if its control bit is still set. A stop request stays in force until a wake source whose mask bit is set fires, or until reset; the wake clears the stored stop bit. Stop always outranks slow mode. Both indicators come straight from flip-flops, so they change only on the rising clock edge and cannot glitch.

Top module: `pm_switchback`

## Requirements
- R1: Writing the control word with bit 0 set makes `slow_o` high after the same rising edge, provided no stop or switchback condition applies. Writing bit 0 clear makes it low after that edge.
- R2: Writing the control word with bit 1 set makes `stop_o` high after the same rising edge. `stop_o` never rises without such a write.
- R3: `slow_o` and `stop_o` are never high together. While stop is in force, `slow_o` is low.
- R4: With switchback enabled (bit 2 set), an edge that samples `irq_busy` high leaves `slow_o` low after that edge.
- R5: With switchback enabled, an edge that samples `uart_busy` high leaves `slow_o` low after that edge.
- R6: With switchback disabled, `irq_busy` and `uart_busy` have no effect on `slow_o`.
- R7: After the last edge that samples activity, `slow_o` stays low for HOLD_CYC further edges. It rises on the edge after those, provided bit 0 is still set and no new activity is seen.
- R8: A `wake_evt` bit i whose mask bit (control bit 3+i) is set clears the stored stop bit, and `stop_o` is low after that edge. A wake bit whose mask bit is clear does not affect `stop_o`.
- R9: When a write that sets the stop bit falls in the same cycle as an enabled wake event, the wake wins: the stop bit is not stored and `stop_o` stays low.
- R10: When a wake ends a stop and bit 0 is still set, `slow_o` rises on the same edge at which `stop_o` falls, unless switchback forces full speed.
- R11: Synchronous active-low reset clears every control bit and drives both outputs low.
- R12: With SLOW_EN = 0, `slow_o` is constantly low. With STOP_EN = 0, `stop_o` is constantly low, whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 3+WAKE_W | Control word: bit 0 slow, bit 1 stop, bit 2 switchback, bits 3.. wake masks |
| irq_busy | input | 1 | An interrupt is pending or being serviced |
| uart_busy | input | 1 | Serial port is transmitting or receiving |
| wake_evt | input | WAKE_W | External wake events, synchronous to clk |
| slow_o | output | 1 | Request to run the core on the slow clock |
| stop_o | output | 1 | Request to halt the core clock |

## Verification
Two functions can meet in one cycle. The first pair is a software write that sets the stop bit and an enabled wake event. The bench issues both in the same cycle and expects `stop_o` to stay low, then checks one more idle cycle to confirm the stop bit was not stored. The second pair is a wake that ends a stop while an interrupt is still busy under switchback. There the bench expects `stop_o` to fall while `slow_o` stays low, and `slow_o` returns only after the hold-off window counted from the last busy edge.

// File: rtl/pmsb_pkg.sv
// Shared constants for the clock switchback controller.
// Assumes the control word is at least 3 bits wide plus one mask bit per wake source.
package pmsb_pkg;
    localparam int CB_SLOW  = 0;  // slow clock mode enable
    localparam int CB_STOP  = 1;  // clock stop request
    localparam int CB_SB    = 2;  // switchback enable
    localparam int CB_WMASK = 3;  // first wake mask bit

    typedef struct packed {
        logic slow;
        logic stop;
        logic sb;
    } pm_mode_t;
endpackage

// File: rtl/pmsb_ctrl_reg.sv
// Control register of the switchback controller.
// Holds the mode bits and the wake masks, and clears the stop bit when an enabled wake arrives.
// Assumes wake events are already synchronous to clk. An enabled wake outranks a write of the stop bit.
module pmsb_ctrl_reg
    import pmsb_pkg::*;
#(
    parameter int WAKE_W  = 2,
    parameter bit SLOW_EN = 1'b1,
    parameter bit STOP_EN = 1'b1,
    localparam int CFG_W  = CB_WMASK + WAKE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic [WAKE_W-1:0] wake_evt,
    output pm_mode_t          mode_d,
    output logic              sb_q,
    output logic [WAKE_W-1:0] wmask_q
);
    pm_mode_t          mode_q;
    logic [WAKE_W-1:0] wmask_d;
    logic              wake_hit;

    // An event counts only when its mask bit is currently set
    assign wake_hit = |(wake_evt & wmask_q);

    // Next-state computation: write first, then wake clears stop
    always_comb begin
        mode_d  = mode_q;
        wmask_d = wmask_q;
        if (cfg_we) begin
            mode_d.slow = cfg_wdata[CB_SLOW];
            mode_d.stop = cfg_wdata[CB_STOP];
            mode_d.sb   = cfg_wdata[CB_SB];
            wmask_d     = cfg_wdata[CB_WMASK +: WAKE_W];
        end
        if (wake_hit) begin
            mode_d.stop = 1'b0;
        end
        if (!SLOW_EN) begin
            mode_d.slow = 1'b0;
        end
        if (!STOP_EN) begin
            mode_d.stop = 1'b0;
        end
    end

    // Register update with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            wmask_q <= '0;
        end else begin
            mode_q  <= mode_d;
            wmask_q <= wmask_d;
        end
    end

    assign sb_q = mode_q.sb;
endmodule

// File: rtl/pmsb_switchback.sv
// Switchback detector: asks for full speed while interrupt or serial activity is seen,
// and for HOLD_CYC edges after the last active edge.
// Assumes irq_busy and uart_busy are synchronous levels.
module pmsb_switchback #(
    parameter int HOLD_CYC = 4,
    localparam int CNT_W   = (HOLD_CYC > 0) ? $clog2(HOLD_CYC + 1) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sb_en,
    input  logic irq_busy,
    input  logic uart_busy,
    output logic force_fast
);
    logic active;

    // Any activity that needs a full-speed clock
    assign active = irq_busy | uart_busy;

    generate
        if (HOLD_CYC > 0) begin : g_hold
            logic [CNT_W-1:0] hold_q;

            // Reload on activity, count down after it
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hold_q <= '0;
                end else if (active) begin
                    hold_q <= CNT_W'(HOLD_CYC);
                end else if (hold_q != '0) begin
                    hold_q <= hold_q - 1'b1;
                end
            end

            // Full speed while active or while the window is open
            assign force_fast = sb_en & (active | (hold_q != '0));
        end else begin : g_nohold
            // No window: full speed only while active
            assign force_fast = sb_en & active;
        end
    endgenerate
endmodule

// File: rtl/pmsb_out_stage.sv
// Output flip-flops for the clock request indicators.
// Stop outranks slow, and switchback blocks slow. Both outputs come from flops.
module pmsb_out_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_d,
    input  logic stop_d,
    input  logic force_fast,
    output logic slow_o,
    output logic stop_o
);
    // Register the indicators so they cannot glitch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slow_o <= 1'b0;
            stop_o <= 1'b0;
        end else begin
            slow_o <= slow_d & ~stop_d & ~force_fast;
            stop_o <= stop_d;
        end
    end
endmodule

// File: rtl/pm_switchback.sv
// Top of the clock slow-down / stop controller with automatic switchback.
// Assumes all inputs are synchronous to clk. The clock divider and the clock gate are outside.
module pm_switchback
    import pmsb_pkg::*;
#(
    parameter int WAKE_W   = 2,
    parameter int HOLD_CYC = 4,
    parameter bit SLOW_EN  = 1'b1,
    parameter bit STOP_EN  = 1'b1,
    localparam int CFG_W   = CB_WMASK + WAKE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              irq_busy,
    input  logic              uart_busy,
    input  logic [WAKE_W-1:0] wake_evt,
    output logic              slow_o,
    output logic              stop_o
);
    pm_mode_t          mode_d;
    logic              sb_q;
    logic [WAKE_W-1:0] wmask_q;
    logic              force_fast;

    pmsb_ctrl_reg #(
        .WAKE_W (WAKE_W),
        .SLOW_EN(SLOW_EN),
        .STOP_EN(STOP_EN)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_wdata(cfg_wdata),
        .wake_evt (wake_evt),
        .mode_d   (mode_d),
        .sb_q     (sb_q),
        .wmask_q  (wmask_q)
    );

    pmsb_switchback #(
        .HOLD_CYC(HOLD_CYC)
    ) u_sb (
        .clk       (clk),
        .rst_n     (rst_n),
        .sb_en     (sb_q),
        .irq_busy  (irq_busy),
        .uart_busy (uart_busy),
        .force_fast(force_fast)
    );

    pmsb_out_stage u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_d    (mode_d.slow),
        .stop_d    (mode_d.stop),
        .force_fast(force_fast),
        .slow_o    (slow_o),
        .stop_o    (stop_o)
    );
endmodule

// File: rtl/pm_switchback_chk.sv
// Property checker for pm_switchback, bound to every instance of it.
module pm_switchback_chk #(
    parameter int WAKE_W  = 2,
    parameter bit SLOW_EN = 1'b1,
    parameter bit STOP_EN = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stop_wr,
    input logic              irq_busy,
    input logic              uart_busy,
    input logic [WAKE_W-1:0] wake_evt,
    input logic              sb_en_q,
    input logic [WAKE_W-1:0] wmask_q,
    input logic              slow_o,
    input logic              stop_o
);
    // R2: stop rises only after a write of the stop bit
    p_stop_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_o) |-> $past(stop_wr));

    // R3: the two requests exclude each other
    p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(slow_o && stop_o));

    // R4: interrupt activity under switchback forces full speed
    p_irq_fast_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_en_q && irq_busy) |=> !slow_o);

    // R5: serial activity under switchback forces full speed
    p_uart_fast_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_en_q && uart_busy) |=> !slow_o);

    // R7: slow mode never re-engages straight out of an active edge
    p_reengage_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slow_o) |-> !$past(sb_en_q && (irq_busy || uart_busy)));

    // R8, R9: an enabled wake always leaves stop low
    p_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(wake_evt & wmask_q)) |=> !stop_o);

    // R11: outputs are low right after reset is released
    p_rst_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!slow_o && !stop_o));

    // R12: removed modes keep their outputs low
    p_par_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (SLOW_EN || !slow_o) && (STOP_EN || !stop_o));
endmodule

bind pm_switchback pm_switchback_chk #(
    .WAKE_W (WAKE_W),
    .SLOW_EN(SLOW_EN),
    .STOP_EN(STOP_EN)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .stop_wr  (cfg_we && cfg_wdata[pmsb_pkg::CB_STOP]),
    .irq_busy (irq_busy),
    .uart_busy(uart_busy),
    .wake_evt (wake_evt),
    .sb_en_q  (sb_q),
    .wmask_q  (wmask_q),
    .slow_o   (slow_o),
    .stop_o   (stop_o)
);

// File: tb/pm_switchback_tb.sv
// Scoreboard bench: the driver queues the expected outputs for each edge, the monitor compares them.
module pm_switchback_tb;
    localparam int WAKE_W = 2;
    localparam int CFG_W  = 3 + WAKE_W;

    typedef struct {
        logic slow;
        logic stop;
        bit   chk;
        int   rid;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [CFG_W-1:0]  cfg_wdata = '0;
    logic              irq_busy = 1'b0;
    logic              uart_busy = 1'b0;
    logic [WAKE_W-1:0] wake_evt = '0;
    logic              slow_o, stop_o, slow_m, stop_m;

    int   n_chk = 0;
    int   n_err = 0;
    bit   done  = 1'b0;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    pm_switchback #(.WAKE_W(WAKE_W), .HOLD_CYC(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .irq_busy(irq_busy), .uart_busy(uart_busy), .wake_evt(wake_evt),
        .slow_o(slow_o), .stop_o(stop_o));

    // Second copy with both modes removed (R12)
    pm_switchback #(.WAKE_W(WAKE_W), .HOLD_CYC(4), .SLOW_EN(1'b0), .STOP_EN(1'b0)) u_min (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .irq_busy(irq_busy), .uart_busy(uart_busy), .wake_evt(wake_evt),
        .slow_o(slow_m), .stop_o(stop_m));

    task automatic check(input logic act, input logic exp, input int rid, input string what);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL R%0d %s: actual=%b expected=%b at %0t", rid, what, act, exp, $time);
        end
    endtask

    // Driver: apply inputs for one edge and queue the outputs expected after it
    task automatic cyc(input logic we, input logic [CFG_W-1:0] wd, input logic irq,
                       input logic uart, input logic [WAKE_W-1:0] wk,
                       input logic es, input logic est, input bit chk, input int rid);
        exp_t e;
        cfg_we = we; cfg_wdata = wd; irq_busy = irq; uart_busy = uart; wake_evt = wk;
        e.slow = es; e.stop = est; e.chk = chk; e.rid = rid;
        sb_q.push_back(e);
        @(negedge clk);
        cfg_we = 1'b0; irq_busy = 1'b0; uart_busy = 1'b0; wake_evt = '0;
    endtask

    // Monitor: compare one queued item shortly after each rising edge
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            if (e.chk) begin
                check(slow_o, e.slow, e.rid, "slow_o");
                check(stop_o, e.stop, e.rid, "stop_o");
                check(slow_m | stop_m, 1'b0, 12, "removed modes");  // R12
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(slow_o, 1'b0, 11, "reset slow");   // R11
        check(stop_o, 1'b0, 11, "reset stop");   // R11
        rst_n = 1'b1;
        @(negedge clk);
        // R1: slow on, then steady
        cyc(1, 5'h01, 0, 0, 2'b00, 1, 0, 1, 1);
        cyc(0, 5'h01, 0, 0, 2'b00, 1, 0, 1, 1);
        // R6: activity ignored without switchback
        cyc(0, 5'h01, 1, 0, 2'b00, 1, 0, 1, 6);
        cyc(0, 5'h01, 0, 1, 2'b00, 1, 0, 1, 6);
        // enable switchback (takes effect from next edge)
        cyc(1, 5'h05, 0, 0, 2'b00, 1, 0, 1, 1);
        // R4: interrupt forces full speed
        cyc(0, 5'h05, 1, 0, 2'b00, 0, 0, 1, 4);
        cyc(0, 5'h05, 1, 0, 2'b00, 0, 0, 1, 4);
        // R7: four hold edges, then slow returns
        for (int i = 0; i < 4; i++) cyc(0, 5'h05, 0, 0, 2'b00, 0, 0, 1, 7);
        cyc(0, 5'h05, 0, 0, 2'b00, 1, 0, 1, 7);
        // R5: serial activity forces full speed, then R7 hold
        cyc(0, 5'h05, 0, 1, 2'b00, 0, 0, 1, 5);
        for (int i = 0; i < 4; i++) cyc(0, 5'h05, 0, 0, 2'b00, 0, 0, 1, 7);
        cyc(0, 5'h05, 0, 0, 2'b00, 1, 0, 1, 7);
        // R1: slow off
        cyc(1, 5'h04, 0, 0, 2'b00, 0, 0, 1, 1);
        // R2, R3: stop with slow set, wake0 enabled
        cyc(1, 5'h0B, 0, 0, 2'b00, 0, 1, 1, 2);
        cyc(0, 5'h0B, 0, 0, 2'b00, 0, 1, 1, 3);
        // R8: unmasked wake1 ignored, serial activity does not wake
        cyc(0, 5'h0B, 0, 0, 2'b10, 0, 1, 1, 8);
        cyc(0, 5'h0B, 0, 1, 2'b00, 0, 1, 1, 8);
        // R8, R10: enabled wake clears stop and slow resumes at once
        cyc(0, 5'h0B, 0, 0, 2'b01, 1, 0, 1, 10);
        cyc(0, 5'h0B, 0, 0, 2'b00, 1, 0, 1, 8);
        // R9: stop write together with enabled wake, then confirm bit not stored
        cyc(1, 5'h0B, 0, 0, 2'b01, 1, 0, 1, 9);
        cyc(0, 5'h0B, 0, 0, 2'b00, 1, 0, 1, 9);
        // R3: stop with switchback and interrupt busy
        cyc(1, 5'h0F, 0, 0, 2'b00, 0, 1, 1, 3);
        cyc(0, 5'h0F, 1, 0, 2'b00, 0, 1, 1, 3);
        // R4, R10: wake while interrupt busy keeps full speed
        cyc(0, 5'h0F, 1, 0, 2'b01, 0, 0, 1, 4);
        for (int i = 0; i < 4; i++) cyc(0, 5'h0F, 0, 0, 2'b00, 0, 0, 1, 7);
        cyc(0, 5'h0F, 0, 0, 2'b00, 1, 0, 1, 10);
        // R11: reset mid-run clears outputs and control
        rst_n = 1'b0;
        cyc(0, 5'h00, 0, 0, 2'b00, 0, 0, 1, 11);
        rst_n = 1'b1;
        cyc(0, 5'h00, 0, 0, 2'b00, 0, 0, 1, 11);
        // R2, R8: stop with no wake mask ignores wake0, software clear
        cyc(1, 5'h02, 0, 0, 2'b00, 0, 1, 1, 2);
        cyc(0, 5'h02, 0, 0, 2'b01, 0, 1, 1, 8);
        cyc(1, 5'h00, 0, 0, 2'b00, 0, 0, 1, 2);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule